// File: doc/BRIEF.md
# Three-Slot Uop Steering with Microcode Handoff

This block sits behind an instruction length decoder. Each cycle it receives up to three instruction descriptors. Each descriptor gives a valid bit, the number of uops the instruction expands to, and an 8-bit tag that stands in for the uop template. The three slots have different abilities. Slot 0 can expand an instruction into as many as four uops. Slots 1 and 2 can only pass an instruction that is a single uop.

An instruction in slot 1 or 2 that needs more than one uop is not emitted. It is also not counted as consumed, so the byte shifter presents it again, and it arrives in slot 0 in a later cycle. An instruction in slot 0 that needs more than four uops is given to a microcode sequencer. The sequencer streams the flow's uops out of a computed ROM, three per cycle, and marks the bundle that ends the flow. While a flow is streaming, the inputs are ignored.

All results are registered. They appear one clock after the inputs that caused them. A hold input from the downstream stage freezes both the state and the outputs.

Top module: `tri_slot_uop_steer`

## Requirements
- R1: While `rst_n` is low, and on the first output after it is released, `uop_vld`, `take_cnt`, `ms_busy` and `ms_end` are all zero. A reset in the middle of a flow abandons that flow.
- R2: A valid slot 0 instruction needing 1 to 4 uops emits those uops in lanes 0 upward. Lane word k is {src=0, tag, idx=k}: bit 12 is src, bits 11:4 are the tag and bits 3:0 are idx. The valid lanes always form a contiguous run that starts at lane 0.
- R3: A valid single-uop instruction in slot 1 is emitted in the lane right after slot 0's uops, but only when slot 0 was emitted normally. Slot 2 then follows in the next lane under the same condition. `take_cnt` equals the number of slots emitted.
- R4: An instruction in slot 1 or 2 needing more than one uop, or an invalid slot, emits nothing. It is not counted in `take_cnt`, and no later slot is emitted or counted, even if that slot holds a single-uop instruction.
- R5: A valid slot 0 instruction needing more than 4 uops starts a flow. That output has `take_cnt`=1, lanes 0..2 carry {src=1, tag, idx=0..2}, slots 1 and 2 are ignored, and `ms_busy` is 1.
- R6: A flow continues with the next indices, three per output at most. On the output that carries the final index (count-1), `ms_end` is 1 and `ms_busy` is 0.
- R7: While `ms_busy` is 1, the inputs are ignored: `take_cnt` is 0 and the lanes carry only the flow's uops.
- R8: On the cycle after the output with `ms_end`, normal decode of the presented slots resumes.
- R9: While `hold` is 1, no output changes and the flow does not advance. The indices continue where they stopped once `hold` drops.
- R10: When slot 0 is invalid, nothing is emitted and `take_cnt` is 0, whatever slots 1 and 2 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Downstream stall; freezes state and outputs |
| slot_vld | input | 3 | Valid bit per slot, bit 0 = slot 0 |
| slot_cnt | input | 12 | Uop count per slot, 4 bits each, slot 0 in bits 3:0 |
| slot_tag | input | 24 | Uop template tag per slot, 8 bits each, slot 0 in bits 7:0 |
| uop_vld | output | 6 | Valid per output lane |
| uop_dat | output | 78 | 13-bit uop word per lane, lane 0 in bits 12:0 |
| ms_end | output | 1 | This bundle ends a microcode flow |
| take_cnt | output | 2 | Leading instructions consumed by the cycle that produced this bundle |
| ms_busy | output | 1 | A flow is still streaming; inputs presented now are ignored |

## Verification
Every result is due exactly one clock edge after the inputs that produced it. The bench drives each input set on a falling edge and samples on the next falling edge, so each check looks at the output of exactly one rising edge. A flow of N uops takes ceil(N/3) consecutive outputs, and the bench checks each of those outputs in turn. Under hold, the bench samples the same outputs for several cycles before releasing hold, and then checks that the next output carries the index that follows the last one emitted.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int TAG_W = 8;
  localparam int CNT_W = 4;
  localparam int SLOTS = 3;

  typedef struct packed {
    logic             src;  // 1: microcode ROM, 0: direct decode
    logic [TAG_W-1:0] tag;
    logic [CNT_W-1:0] idx;
  } uop_t;

  localparam int UW = $bits(uop_t);

  // Microcode ROM contents are computed from the flow tag and step index.
  function automatic uop_t rom_word(input logic [TAG_W-1:0] tag, input logic [CNT_W-1:0] idx);
    rom_word = '{src: 1'b1, tag: tag, idx: idx};
  endfunction

  function automatic uop_t dec_word(input logic [TAG_W-1:0] tag, input logic [CNT_W-1:0] idx);
    dec_word = '{src: 1'b0, tag: tag, idx: idx};
  endfunction

  // Uops taken from a flow this cycle: the smaller of what remains and the lane budget.
  function automatic logic [CNT_W-1:0] chunk(input logic [CNT_W-1:0] rem, input logic [CNT_W-1:0] per);
    chunk = (rem > per) ? per : rem;
  endfunction
endpackage

// File: rtl/steer_slot_gate.sv
module steer_slot_gate
  import steer_pkg::*;
#(
  parameter int S0_MAX = 4
) (
  input  logic [SLOTS-1:0]            vld,
  input  logic [SLOTS-1:0][CNT_W-1:0] cnt,
  output logic [SLOTS-1:0]            pass,
  output logic                        ms_start,
  output logic [1:0]                  take
);
  localparam logic [CNT_W-1:0] S0C = CNT_W'(S0_MAX);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb begin
    pass[0]  = vld[0] && (cnt[0] <= S0C);
    ms_start = vld[0] && (cnt[0] > S0C);
    for (int s = 1; s < SLOTS; s++)
      pass[s] = pass[s-1] && vld[s] && (cnt[s] == ONE);
    if (ms_start) take = 2'd1;
    else          take = {1'b0, pass[0]} + {1'b0, pass[1]} + {1'b0, pass[2]};
  end
endmodule

// File: rtl/steer_useq.sv
module steer_useq
  import steer_pkg::*;
#(
  parameter int MS_PER = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  input  logic [CNT_W-1:0] start_cnt,
  output logic             run,
  output logic [CNT_W-1:0] emit_n,
  output logic [CNT_W-1:0] emit_base,
  output logic [TAG_W-1:0] emit_tag,
  output logic             emit_last
);
  localparam logic [CNT_W-1:0] MSC = CNT_W'(MS_PER);

  logic             run_q;
  logic [TAG_W-1:0] tag_q;
  logic [CNT_W-1:0] total_q, nxt_q, rem;

  assign run       = run_q;
  assign rem       = run_q ? (total_q - nxt_q) : start_cnt;
  assign emit_n    = chunk(rem, MSC);
  assign emit_last = (rem <= MSC);
  assign emit_base = run_q ? nxt_q : '0;
  assign emit_tag  = run_q ? tag_q : start_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      tag_q   <= '0;
      total_q <= '0;
      nxt_q   <= '0;
    end else if (adv && (run_q || start)) begin
      run_q <= !emit_last;
      nxt_q <= emit_base + emit_n;
      if (!run_q) begin
        tag_q   <= start_tag;
        total_q <= start_cnt;
      end
    end
  end

  // R6: an active flow always has uops left and makes progress
  p_flow_progress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (nxt_q < total_q) && (emit_n != '0));
  // R9: a stalled flow keeps its position
  p_flow_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(nxt_q) && $stable(run_q));
endmodule

// File: rtl/tri_slot_uop_steer.sv
module tri_slot_uop_steer
  import steer_pkg::*;
#(
  parameter int S0_MAX = 4,
  parameter int MS_PER = 3,
  localparam int L = S0_MAX + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hold,
  input  logic [SLOTS-1:0]       slot_vld,
  input  logic [SLOTS*CNT_W-1:0] slot_cnt,
  input  logic [SLOTS*TAG_W-1:0] slot_tag,
  output logic [L-1:0]           uop_vld,
  output logic [L*UW-1:0]        uop_dat,
  output logic                   ms_end,
  output logic [1:0]             take_cnt,
  output logic                   ms_busy
);
  logic [SLOTS-1:0][CNT_W-1:0] cnt;
  logic [SLOTS-1:0][TAG_W-1:0] tag;
  assign cnt = slot_cnt;
  assign tag = slot_tag;

  logic [SLOTS-1:0] pass;
  logic             ms_req, ms_start;
  logic [1:0]       dec_take;

  steer_slot_gate #(.S0_MAX(S0_MAX)) u_gate (
    .vld(slot_vld), .cnt(cnt), .pass(pass), .ms_start(ms_req), .take(dec_take)
  );

  logic             seq_run, seq_last;
  logic [CNT_W-1:0] seq_n, seq_base;
  logic [TAG_W-1:0] seq_tag;

  assign ms_start = ms_req && !seq_run;

  steer_useq #(.MS_PER(MS_PER)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(!hold), .start(ms_start),
    .start_tag(tag[0]), .start_cnt(cnt[0]),
    .run(seq_run), .emit_n(seq_n), .emit_base(seq_base),
    .emit_tag(seq_tag), .emit_last(seq_last)
  );

  logic [L-1:0]       nx_vld;
  uop_t [L-1:0]       nx_dat;
  logic               nx_end, nx_busy;
  logic [1:0]         nx_take;

  always_comb begin
    nx_vld = '0;
    nx_dat = '0;
    if (seq_run || ms_start) begin
      for (int i = 0; i < L; i++)
        if (i < MS_PER && CNT_W'(i) < seq_n) begin
          nx_vld[i] = 1'b1;
          nx_dat[i] = rom_word(seq_tag, seq_base + CNT_W'(i));
        end
      nx_take = seq_run ? 2'd0 : 2'd1;
      nx_end  = seq_last;
      nx_busy = !seq_last;
    end else begin
      for (int i = 0; i < L; i++) begin
        if (pass[0] && CNT_W'(i) < cnt[0]) begin
          nx_vld[i] = 1'b1;
          nx_dat[i] = dec_word(tag[0], CNT_W'(i));
        end else if (pass[1] && CNT_W'(i) == cnt[0]) begin
          nx_vld[i] = 1'b1;
          nx_dat[i] = dec_word(tag[1], '0);
        end else if (pass[2] && CNT_W'(i) == cnt[0] + CNT_W'(1)) begin
          nx_vld[i] = 1'b1;
          nx_dat[i] = dec_word(tag[2], '0);
        end
      end
      nx_take = dec_take;
      nx_end  = 1'b0;
      nx_busy = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uop_vld  <= '0;
      uop_dat  <= '0;
      ms_end   <= 1'b0;
      take_cnt <= '0;
      ms_busy  <= 1'b0;
    end else if (!hold) begin
      uop_vld  <= nx_vld;
      uop_dat  <= nx_dat;
      ms_end   <= nx_end;
      take_cnt <= nx_take;
      ms_busy  <= nx_busy;
    end
  end

  // R2: valid lanes form one run starting at lane 0
  p_lanes_packed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_vld & (uop_vld + L'(1))) == '0);
  // R6: the bundle ending a flow leaves the sequencer idle
  p_end_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ms_end |-> !ms_busy);
  // R6: a bundle that leaves the flow running is a full sequencer bundle
  p_busy_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ms_busy |-> $countones(uop_vld) == MS_PER);
  // R7: nothing is consumed while streaming
  p_busy_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ms_busy && !hold |=> take_cnt == 2'd0);
  // R9: hold freezes every output
  p_hold_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(uop_vld) && $stable(uop_dat) && $stable(take_cnt)
             && $stable(ms_busy) && $stable(ms_end));
endmodule

// File: tb/sim_tri_slot_uop_steer.sv
module sim_tri_slot_uop_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold = 1'b0;
  logic [2:0]  slot_vld = '0;
  logic [11:0] slot_cnt = '0;
  logic [23:0] slot_tag = '0;
  logic [5:0]  uop_vld;
  logic [77:0] uop_dat;
  logic        ms_end, ms_busy;
  logic [1:0]  take_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tri_slot_uop_steer u0 (
    .clk(clk), .rst_n(rst_n), .hold(hold), .slot_vld(slot_vld),
    .slot_cnt(slot_cnt), .slot_tag(slot_tag), .uop_vld(uop_vld),
    .uop_dat(uop_dat), .ms_end(ms_end), .take_cnt(take_cnt), .ms_busy(ms_busy)
  );

  // {vld[2:0], c0, c1, c2, take, lanes, busy, end}
  localparam int NV = 15;
  localparam logic [21:0] VEC [NV] = '{
    {3'b001, 4'd1, 4'd0, 4'd0, 2'd1, 3'd1, 1'b0, 1'b0},  // R2
    {3'b111, 4'd1, 4'd1, 4'd1, 2'd3, 3'd3, 1'b0, 1'b0},  // R3
    {3'b111, 4'd4, 4'd1, 4'd1, 2'd3, 3'd6, 1'b0, 1'b0},  // R2 R3
    {3'b111, 4'd3, 4'd2, 4'd1, 2'd1, 3'd3, 1'b0, 1'b0},  // R4
    {3'b111, 4'd1, 4'd1, 4'd3, 2'd2, 3'd2, 1'b0, 1'b0},  // R4
    {3'b101, 4'd2, 4'd1, 4'd1, 2'd1, 3'd2, 1'b0, 1'b0},  // R4 gap
    {3'b000, 4'd1, 4'd1, 4'd1, 2'd0, 3'd0, 1'b0, 1'b0},  // R10
    {3'b110, 4'd1, 4'd1, 4'd1, 2'd0, 3'd0, 1'b0, 1'b0},  // R10
    {3'b111, 4'd7, 4'd1, 4'd1, 2'd1, 3'd3, 1'b1, 1'b0},  // R5
    {3'b111, 4'd1, 4'd1, 4'd1, 2'd0, 3'd3, 1'b1, 1'b0},  // R7
    {3'b111, 4'd1, 4'd1, 4'd1, 2'd0, 3'd1, 1'b0, 1'b1},  // R6
    {3'b111, 4'd1, 4'd1, 4'd1, 2'd3, 3'd3, 1'b0, 1'b0},  // R8
    {3'b001, 4'd5, 4'd0, 4'd0, 2'd1, 3'd3, 1'b1, 1'b0},  // R5
    {3'b111, 4'd4, 4'd1, 4'd1, 2'd0, 3'd2, 1'b0, 1'b1},  // R6 R7
    {3'b001, 4'd4, 4'd0, 4'd0, 2'd1, 3'd4, 1'b0, 1'b0}   // R8
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int lane(input int i);
    return int'(uop_dat[i*13 +: 13]);
  endfunction

  function automatic int word(input bit src, input int tg, input int idx);
    return (int'(src) << 12) | ((tg & 255) << 4) | (idx & 15);
  endfunction

  task automatic drive(input logic [2:0] v, input int c0, input int c1, input int c2,
                       input int t0, input int t1, input int t2);
    slot_vld = v;
    slot_cnt = {4'(c2), 4'(c1), 4'(c0)};
    slot_tag = {8'(t2), 8'(t1), 8'(t0)};
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs during reset
    drive(3'b111, 1, 1, 1, 1, 2, 3);
    repeat (3) step();
    check("R1 vld", int'(uop_vld), 0);
    check("R1 take", int'(take_cnt), 0);
    check("R1 busy", int'(ms_busy), 0);
    check("R1 end", int'(ms_end), 0);
    rst_n = 1'b1;

    // table walk: one vector per cycle, output due at the next falling edge
    for (int k = 0; k < NV; k++) begin
      logic [21:0] e;
      e = VEC[k];
      drive(e[21:19], int'(e[18:15]), int'(e[14:11]), int'(e[10:7]),
            (k << 4) | 1, (k << 4) | 5, (k << 4) | 9);
      step();
      check($sformatf("R3 take v%0d", k), int'(take_cnt), int'(e[6:5]));
      check($sformatf("R2 lanes v%0d", k), $countones(uop_vld), int'(e[4:2]));
      check($sformatf("R2 packed v%0d", k), int'((uop_vld & (uop_vld + 6'd1)) == 6'd0), 1);
      check($sformatf("R5 busy v%0d", k), int'(ms_busy), int'(e[1]));
      check($sformatf("R6 end v%0d", k), int'(ms_end), int'(e[0]));
    end

    // R2 R3: lane words for direct decode
    drive(3'b111, 3, 1, 1, 8'hAA, 8'hBB, 8'hCC);
    step();
    for (int i = 0; i < 3; i++) check("R2 word", lane(i), word(0, 8'hAA, i));
    check("R3 slot1 word", lane(3), word(0, 8'hBB, 0));
    check("R3 slot2 word", lane(4), word(0, 8'hCC, 0));

    // R5 R6 R7: a five-uop flow with single-uop neighbours ignored
    drive(3'b111, 5, 1, 1, 8'h3C, 8'h11, 8'h22);
    step();
    for (int i = 0; i < 3; i++) check("R5 rom word", lane(i), word(1, 8'h3C, i));
    check("R5 lanes", $countones(uop_vld), 3);
    drive(3'b111, 1, 1, 1, 8'h44, 8'h55, 8'h66);
    step();
    check("R6 rom word3", lane(0), word(1, 8'h3C, 3));
    check("R6 rom word4", lane(1), word(1, 8'h3C, 4));
    check("R7 take", int'(take_cnt), 0);
    check("R6 end", int'(ms_end), 1);
    step();
    check("R8 resume", lane(0), word(0, 8'h44, 0));

    // R9: hold in the middle of an eight-uop flow
    drive(3'b001, 8, 0, 0, 8'h5A, 0, 0);
    step();
    check("R5 start busy", int'(ms_busy), 1);
    hold = 1'b1;
    drive(3'b111, 1, 1, 1, 8'h01, 8'h02, 8'h03);
    step();
    step();
    check("R9 frozen word", lane(0), word(1, 8'h5A, 0));
    check("R9 frozen busy", int'(ms_busy), 1);
    check("R9 frozen take", int'(take_cnt), 1);
    hold = 1'b0;
    step();
    check("R9 resumes idx", lane(0), word(1, 8'h5A, 3));
    step();
    check("R9 last idx", lane(1), word(1, 8'h5A, 7));
    check("R6 end after hold", int'(ms_end), 1);

    // R1: reset abandons a flow
    drive(3'b001, 9, 0, 0, 8'h77, 0, 0);
    step();
    rst_n = 1'b0;
    step();
    check("R1 mid-flow busy", int'(ms_busy), 0);
    check("R1 mid-flow vld", int'(uop_vld), 0);
    rst_n = 1'b1;
    drive(3'b001, 1, 0, 0, 8'h12, 0, 0);
    step();
    check("R1 after reset take", int'(take_cnt), 1);
    check("R1 after reset word", lane(0), word(0, 8'h12, 0));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule